// File: doc/BRIEF.md
# Byte-Serial AES Column Mixer

This block applies the AES column-mixing transform to one four-byte state column, taking one byte per clock. Each incoming byte is multiplied by a small set of GF(2^8) constants. The products are folded into four 8-bit accumulators that pass partial sums around a ring. After the fourth byte, the four accumulators hold the whole transformed column.

A single input selects the direction. The forward transform serves encryption and the inverse transform serves decryption. Both directions share the same ring; only the constant multipliers differ. The caller raises the start strobe with the first byte of a column and sets the direction in that same cycle. It then presents the remaining three bytes on consecutive cycles. One cycle after the fourth byte is clocked in, the outputs carry the result and the valid flag is high for that cycle. A new column may start in that same cycle, so columns can stream with no gap.

Top module: `aes_colmix`

## Requirements
- R1: With dir_i=0 at start, input bytes y0..y3 (y0 with the strobe) give col0_o..col3_o equal to rows 0..3 of the circulant forward matrix, whose row 0 is {02,03,01,01}, in the cycle that valid_o is high. The field multiplication uses the polynomial x^8+x^4+x^3+x+1. The column db,13,53,45 maps to 8e,4d,a1,bc.
- R2: With dir_i=1 at start, the outputs equal the circulant inverse matrix applied to y0..y3, whose row 0 is {0e,0b,0d,09}. The column 8e,4d,a1,bc maps back to db,13,53,45.
- R3: valid_o is high for exactly one cycle: the cycle after the fourth byte of a column is clocked in. It stays low during the three cycles before that.
- R4: valid_o never rises for bytes that follow reset or a completed column when no start strobe has been given.
- R5: A start strobe in the middle of a column discards the partial column. The result and valid_o follow from the latest strobe only.
- R6: dir_i is sampled only in the start cycle. Changing it during the other three bytes does not change the result.
- R7: While rst_ni is low, all column outputs read 0 and valid_o is 0. This takes effect at once, without waiting for a clock edge.
- R8: Columns may be sent back to back, with the next strobe in the cycle valid_o is high. Each column then gives a correct result one cycle after its own fourth byte.
- R9: Feeding the forward result of any column back through the inverse direction returns the original column.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| byte_i | input | 8 | Column byte, one per cycle |
| start_i | input | 1 | Marks the first byte of a column |
| dir_i | input | 1 | 0 forward, 1 inverse; sampled with start_i |
| col0_o | output | 8 | Result byte 0 |
| col1_o | output | 8 | Result byte 1 |
| col2_o | output | 8 | Result byte 2 |
| col3_o | output | 8 | Result byte 3 |
| valid_o | output | 1 | Result valid, one cycle per column |

## Verification
The bench sweeps every byte value through each of the four column positions in both directions, back to back. A wrong reduction bit, a swapped coefficient or a mis-wired rotation would therefore corrupt a specific output lane for some values. A restart after two bytes would show up as leftover partial sums or an early valid flag. Flipping the direction in mid-column catches a design that reads the select live instead of latching it. Runs of bytes without a strobe would expose a counter that wraps and raises valid on its own. Random round trips and the standard column check that the two directions are true inverses.

// File: rtl/aes_colmix_pkg.sv
package aes_colmix_pkg;
  localparam int BYTE_W = 8;
  localparam int SLOTS  = 4;
  localparam int CNT_W  = $clog2(SLOTS);

  typedef logic [BYTE_W-1:0] byte_t;

  // multiply by x modulo x^8+x^4+x^3+x+1
  function automatic byte_t gf_x2(byte_t a);
    return {a[6:0], 1'b0} ^ {3'b000, a[7], a[7], 1'b0, a[7], a[7]};
  endfunction
endpackage

// File: rtl/aes_colmix_terms.sv
module aes_colmix_terms
  import aes_colmix_pkg::*;
(
  input  byte_t                        x_i,
  input  logic                         inv_i,
  output logic [SLOTS-1:0][BYTE_W-1:0] term_o
);
  byte_t x2, x4, x8;

  assign x2 = gf_x2(x_i);
  assign x4 = gf_x2(x2);
  assign x8 = gf_x2(x4);

  // slot terms: fwd {1,1,3,2}, inv {9,d,b,e}
  always_comb begin
    if (inv_i) begin
      term_o[0] = x8 ^ x_i;
      term_o[1] = x8 ^ x4 ^ x_i;
      term_o[2] = x8 ^ x2 ^ x_i;
      term_o[3] = x8 ^ x4 ^ x2;
    end else begin
      term_o[0] = x_i;
      term_o[1] = x_i;
      term_o[2] = x2 ^ x_i;
      term_o[3] = x2;
    end
  end
endmodule

// File: rtl/aes_colmix_ring.sv
module aes_colmix_ring
  import aes_colmix_pkg::*;
(
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic                         load_i,
  input  logic [SLOTS-1:0][BYTE_W-1:0] term_i,
  output logic [SLOTS-1:0][BYTE_W-1:0] acc_o
);
  for (genvar i = 0; i < SLOTS; i++) begin : g_slot
    localparam int NXT = (i + 1) % SLOTS;

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)     acc_o[i] <= '0;
      else if (load_i) acc_o[i] <= term_i[i];
      else             acc_o[i] <= term_i[i] ^ acc_o[NXT];
    end

    // R5: a strobe drops any partial sum
    a_r5_slot_reload: assert property (@(posedge clk_i) disable iff (!rst_ni)
      load_i |=> acc_o[i] == $past(term_i[i]));
  end
endmodule

// File: rtl/aes_colmix_ctrl.sv
module aes_colmix_ctrl
  import aes_colmix_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  input  logic dir_i,
  output logic inv_sel_o,
  output logic valid_o
);
  logic [CNT_W-1:0] cnt_q;
  logic             busy_q;
  logic             dir_q;

  assign inv_sel_o = start_i ? dir_i : dir_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q   <= '0;
      busy_q  <= 1'b0;
      dir_q   <= 1'b0;
      valid_o <= 1'b0;
    end else if (start_i) begin
      cnt_q   <= CNT_W'(1);
      busy_q  <= 1'b1;
      dir_q   <= dir_i;
      valid_o <= 1'b0;
    end else begin
      valid_o <= 1'b0;
      if (busy_q) begin
        cnt_q <= cnt_q + 1'b1;
        if (cnt_q == CNT_W'(SLOTS - 1)) begin
          busy_q  <= 1'b0;
          valid_o <= 1'b1;
        end
      end
    end
  end

  a_r3_valid_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |=> !valid_o);

  a_r6_dir_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !start_i |=> $stable(dir_q));

  a_r5_count_restart: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> (cnt_q == CNT_W'(1)) && busy_q && !valid_o);
endmodule

// File: rtl/aes_colmix.sv
module aes_colmix
  import aes_colmix_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic [7:0] byte_i,
  input  logic       start_i,
  input  logic       dir_i,
  output logic [7:0] col0_o,
  output logic [7:0] col1_o,
  output logic [7:0] col2_o,
  output logic [7:0] col3_o,
  output logic       valid_o
);
  logic                         inv_sel;
  logic [SLOTS-1:0][BYTE_W-1:0] term;
  logic [SLOTS-1:0][BYTE_W-1:0] acc;

  aes_colmix_ctrl u_ctrl (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .start_i   (start_i),
    .dir_i     (dir_i),
    .inv_sel_o (inv_sel),
    .valid_o   (valid_o)
  );

  aes_colmix_terms u_terms (
    .x_i    (byte_i),
    .inv_i  (inv_sel),
    .term_o (term)
  );

  aes_colmix_ring u_ring (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (start_i),
    .term_i (term),
    .acc_o  (acc)
  );

  assign col0_o = acc[0];
  assign col1_o = acc[1];
  assign col2_o = acc[2];
  assign col3_o = acc[3];

  // R1, R2: coefficients of each direction XOR to 01
  a_r1_term_sum: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (term[0] ^ term[1] ^ term[2] ^ term[3]) == byte_i);

  // R3, R4: valid only four edges after a strobe with none since
  a_r3_valid_after_four: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> $past(start_i, 4) && !$past(start_i, 3) &&
                !$past(start_i, 2) && !$past(start_i, 1));
endmodule

// File: tb/aes_colmix_tb_top.sv
module aes_colmix_tb_top;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic [7:0] byte_i = '0;
  logic       start_i = 1'b0;
  logic       dir_i = 1'b0;
  logic [7:0] col0_o, col1_o, col2_o, col3_o;
  logic       valid_o;
  int         total = 0;
  int         bad = 0;

  always #5 clk_i = ~clk_i;

  aes_colmix dut_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .byte_i(byte_i), .start_i(start_i),
    .dir_i(dir_i), .col0_o(col0_o), .col1_o(col1_o), .col2_o(col2_o),
    .col3_o(col3_o), .valid_o(valid_o)
  );

  function automatic logic [7:0] gmul(logic [7:0] a, logic [7:0] b);
    logic [8:0] aa = {1'b0, a};
    logic [7:0] p = '0;
    for (int i = 0; i < 8; i++) begin
      if (b[i]) p ^= aa[7:0];
      aa = aa << 1;
      if (aa[8]) aa ^= 9'h11b;
    end
    return p;
  endfunction

  // circulant: coef[r][j] = base[(j - r) mod 4]
  function automatic logic [31:0] ref_mix(logic [31:0] c, logic inv);
    logic [7:0] base [4];
    logic [31:0] r = '0;
    if (inv) begin base[0]=8'h0e; base[1]=8'h0b; base[2]=8'h0d; base[3]=8'h09; end
    else     begin base[0]=8'h02; base[1]=8'h03; base[2]=8'h01; base[3]=8'h01; end
    for (int row = 0; row < 4; row++)
      for (int j = 0; j < 4; j++)
        r[8*row +: 8] ^= gmul(base[(j - row + 4) % 4], c[8*j +: 8]);
    return r;
  endfunction

  function automatic logic [31:0] outs();
    return {col3_o, col2_o, col1_o, col0_o};
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%h exp=%h at %0t", req, act, exp, $time);
    end
  endtask

  // called at a negedge; returns at the negedge where the result is valid
  task automatic run_col(input logic [31:0] c, input logic inv, input bit wiggle,
                         input string req, output logic [31:0] res);
    for (int k = 0; k < 4; k++) begin
      byte_i  = c[8*k +: 8];
      start_i = (k == 0);
      dir_i   = (k == 0) ? inv : (wiggle ? ~inv : inv);
      @(negedge clk_i);
      if (k < 3) chk(valid_o == 1'b0, "R3", {31'd0, valid_o}, 32'd0);
    end
    start_i = 1'b0;
    chk(valid_o == 1'b1, "R3", {31'd0, valid_o}, 32'd1);
    res = outs();
    chk(res == ref_mix(c, inv), req, res, ref_mix(c, inv));
  endtask

  task automatic idle_bytes(input int n, input string req);
    for (int k = 0; k < n; k++) begin
      byte_i  = 8'($urandom);
      start_i = 1'b0;
      dir_i   = 1'($urandom);
      @(negedge clk_i);
      chk(valid_o == 1'b0, req, {31'd0, valid_o}, 32'd0);
    end
  endtask

  initial begin
    #1_000_000;
    total++; bad++;
    $display("FAIL watchdog act=timeout exp=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [31:0] res, fw;
    repeat (3) @(negedge clk_i);
    // R7 reset state
    chk(outs() == 32'd0 && valid_o == 1'b0, "R7", outs(), 32'd0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    // R4 bytes without strobe after reset
    idle_bytes(8, "R4");

    // R1, R2 standard column
    run_col(32'h455313db, 1'b0, 1'b0, "R1", res);
    chk(res == 32'hbca14d8e, "R1", res, 32'hbca14d8e);
    run_col(32'hbca14d8e, 1'b1, 1'b0, "R2", res);
    chk(res == 32'h455313db, "R2", res, 32'h455313db);
    // R3 single cycle, then R4 no strobe after a column
    @(negedge clk_i);
    chk(valid_o == 1'b0, "R3", {31'd0, valid_o}, 32'd0);
    idle_bytes(6, "R4");

    // R8 sweep: every value in every position, both directions, back to back
    for (int pos = 0; pos < 4; pos++)
      for (int v = 0; v < 256; v++) begin
        logic [31:0] c = $urandom;
        c[8*pos +: 8] = 8'(v);
        run_col(c, 1'b0, 1'b0, "R8", res);
        run_col(c, 1'b1, 1'b0, "R8", res);
      end

    // R6 direction changes mid-column ignored
    for (int n = 0; n < 40; n++) begin
      run_col($urandom, 1'(n), 1'b1, "R6", res);
    end

    // R5 restart after two bytes
    for (int n = 0; n < 20; n++) begin
      byte_i = 8'($urandom); start_i = 1'b1; dir_i = 1'(~n);
      @(negedge clk_i);
      byte_i = 8'($urandom); start_i = 1'b0;
      @(negedge clk_i);
      chk(valid_o == 1'b0, "R5", {31'd0, valid_o}, 32'd0);
      run_col($urandom, 1'(n), 1'b0, "R5", res);
    end

    // R9 round trip
    for (int n = 0; n < 200; n++) begin
      logic [31:0] c = $urandom;
      run_col(c, 1'b0, 1'b0, "R9", fw);
      run_col(fw, 1'b1, 1'b0, "R9", res);
      chk(res == c, "R9", res, c);
    end

    // R7 asynchronous reset mid-column
    byte_i = 8'h5a; start_i = 1'b1; dir_i = 1'b0;
    @(negedge clk_i);
    start_i = 1'b0; byte_i = 8'hc3;
    @(negedge clk_i);
    rst_ni = 1'b0;
    #1;
    chk(outs() == 32'd0 && valid_o == 1'b0, "R7", outs(), 32'd0);
    @(negedge clk_i);
    rst_ni = 1'b1;
    idle_bytes(5, "R4");
    run_col(32'h455313db, 1'b0, 1'b0, "R1", res);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule